// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter that advances on a slow tick-enable input, synchronous to the system clock. Software must restart it with a clear-request strobe before it runs through a full overflow period. A 3-bit period select picks one of eight period lengths. A 2-bit window mode decides how early in the period a clear may come. A clear that arrives before the window opens counts as a fault, and so does a full period without any clear. Either fault produces a one-cycle watchdog reset pulse and restarts the count.

The four shortest periods always run without a window, whatever the mode bits hold. A flag output is raised three quarters of the way through each period. A handler can react to it, and as a fail-safe it can deliberately clear too early to force the reset.

The period lengths scale with the parameter `BASE_LOG2`. With the default of 3 and a 1.024 kHz tick, the periods run from roughly 7.8 ms to roughly 8 s.

Top module: `win_watchdog`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the count returns to zero and both `wdt_rst_o` and `irq_o` are 0 after that edge.
- R2: With B = `BASE_LOG2`, select code k gives a period of P = 2^(B+k) ticks for k = 0..3 and P = 2^(B+2k-4) ticks for k = 4..7 (8, 16, 32, 64, 128, 512, 2048, 8192 for B = 3). If no clear arrives, the P-th tick after a restart raises `wdt_rst_o` on the following clock edge.
- R3: The reset pulse lasts exactly one cycle. The count restarts from zero at the same edge, so the next overflow comes after another P ticks.
- R4: Window mode encoding is 2'b00 for no window, 2'b01 for a window that opens at P/4 elapsed ticks, 2'b10 for a window that opens at P/2 elapsed ticks, and 2'b11 for no window.
- R5: A clear request seen when the elapsed tick count is at or beyond the window opening is accepted. It gives no reset and restarts the count from zero at the next edge.
- R6: A clear request seen while the window is enabled and the elapsed count is below the opening is invalid. It raises `wdt_rst_o` for one cycle at the next edge and also restarts the count.
- R7: For select codes 0 to 3 the window is disabled for every mode value, so a clear at any elapsed count is accepted.
- R8: When a clear request and a tick share a cycle, the clear wins and the tick is not counted. The window test uses the count held before that cycle.
- R9: `irq_o` rises at the edge where the elapsed count reaches 3P/4. It stays high until a clear request (valid or not) or an overflow, and either of these drops it at the next edge.
- R10: Cycles without a tick and without a clear leave the count, `wdt_rst_o` low and `irq_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count enable, one clock wide per slow tick |
| clr_req_i | input | 1 | Software clear request strobe |
| period_sel_i | input | 3 | Overflow period select code |
| win_mode_i | input | 2 | Window mode (00/11 none, 01 late 75%, 10 late 50%) |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |
| irq_o | output | 1 | Flag raised at 3/4 of the period |

## Verification
The bench runs with the period base shrunk so that every select code fits in the run. For every select and mode pair, it lets the counter run free through two periods and checks the reset and flag outputs on every tick. This separates the eight period lengths and shows that the count restarts after a pulse. Clear requests are swept over every elapsed count for the five shortest periods. For the three longest periods they are placed at the count just before the window opening, at the opening itself, and at both ends of the period. This separates the four mode codes and the forced window-off behaviour of the short periods. Further sequences place a tick and a clear in the same cycle on both sides of the window edge, and insert idle gaps to show that only ticks move the count.

// File: rtl/wdt_pkg.sv
// Package: shared encodings and period arithmetic for the windowed watchdog.
// Assumes period select values 0..7 and a base exponent small enough
// that 2^(BASE_LOG2+10) fits in a 32-bit int.
package wdt_pkg;

    localparam int SEL_W        = 3;
    localparam int NUM_PERIODS  = 8;
    localparam int FIRST_WIN_SEL = 4;
    localparam int LOG2_SPAN    = 10;

    typedef enum logic [1:0] {
        WIN_NONE     = 2'b00,
        WIN_QUARTER  = 2'b01,
        WIN_HALF     = 2'b10,
        WIN_NONE_ALT = 2'b11
    } win_mode_e;

    // Exponent of the period length for a select code.
    function automatic int period_log2(input int base, input int sel);
        return (sel < FIRST_WIN_SEL) ? (base + sel) : (base + 2 * sel - 4);
    endfunction

endpackage

// File: rtl/wdt_period_decode.sv
// Module: wdt_period_decode
// Turns the period select and window mode into the count values the
// rest of the watchdog compares against: last count before overflow,
// window opening count, flag count and a window-enable bit.
// Assumes the select and mode inputs are stable while the count runs.
module wdt_period_decode
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 3,
    parameter int CNT_W     = BASE_LOG2 + LOG2_SPAN
) (
    input  logic [SEL_W-1:0] period_sel_i,
    input  logic [1:0]       win_mode_i,
    output logic [CNT_W-1:0] last_cnt_o,
    output logic [CNT_W-1:0] open_cnt_o,
    output logic [CNT_W-1:0] irq_cnt_o,
    output logic             win_en_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] last_tab    [NUM_PERIODS];
    logic [CNT_W-1:0] quarter_tab [NUM_PERIODS];
    logic [CNT_W-1:0] half_tab    [NUM_PERIODS];
    logic [CNT_W-1:0] irq_tab     [NUM_PERIODS];

    // Constant tables, one entry per select code.
    for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_tab
        localparam int               PL2  = period_log2(BASE_LOG2, g);
        localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << PL2) - 1);
        assign last_tab[g]    = LAST;
        assign quarter_tab[g] = (LAST >> 2) + ONE;
        assign half_tab[g]    = (LAST >> 1) + ONE;
        assign irq_tab[g]     = LAST - (LAST >> 2);
    end

    logic short_period;
    logic mode_windowed;

    // Select the active period values and decide whether the window applies.
    always_comb begin
        short_period  = (int'(period_sel_i) < FIRST_WIN_SEL);
        mode_windowed = (win_mode_i == WIN_QUARTER) || (win_mode_i == WIN_HALF);
        win_en_o      = mode_windowed && !short_period;
        last_cnt_o    = last_tab[period_sel_i];
        irq_cnt_o     = irq_tab[period_sel_i];
        if (!win_en_o) begin
            open_cnt_o = '0;
        end else if (win_mode_i == WIN_QUARTER) begin
            open_cnt_o = quarter_tab[period_sel_i];
        end else begin
            open_cnt_o = half_tab[period_sel_i];
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
// Module: wdt_tick_counter
// Elapsed-tick counter. A restart request wins over a tick in the same
// cycle. The counter wraps to zero after the last count and flags it.
// Assumes tick_i is a single-cycle enable synchronous to clk_i.
module wdt_tick_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] last_cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Detect the tick that completes a full period.
    always_comb begin
        wrap_o = tick_i && !restart_i && (cnt_q == last_cnt_i);
    end

    // Advance, wrap or restart the elapsed count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i || wrap_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_clear_judge.sv
// Module: wdt_clear_judge
// Decides whether a clear request falls inside the permitted window and
// produces the one-cycle watchdog reset pulse for an early clear or a
// completed period. Assumes cnt_i is the count before this cycle's update.
module wdt_clear_judge #(
    parameter int CNT_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             wrap_i,
    input  logic             win_en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] open_cnt_i,
    output logic             wdt_rst_o
);

    logic early_clr;
    logic rst_q;

    // A clear is early only when the window applies and has not opened.
    always_comb begin
        early_clr = clr_i && win_en_i && (cnt_i < open_cnt_i);
    end

    // Register the reset pulse for either fault.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rst_q <= 1'b0;
        end else begin
            rst_q <= early_clr || wrap_i;
        end
    end

    assign wdt_rst_o = rst_q;

endmodule

// File: rtl/wdt_irq_flag.sv
// Module: wdt_irq_flag
// Sticky flag raised when a tick brings the count to the flag point.
// Dropped by any clear request or by a period overflow.
// Assumes cnt_i is the count before this cycle's update.
module wdt_irq_flag #(
    parameter int CNT_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] irq_cnt_i,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic hit;
    logic flag_q;

    // The counted tick lands exactly on the flag point.
    always_comb begin
        hit = tick_i && !clr_i && !wrap_i && ((cnt_i + ONE) == irq_cnt_i);
    end

    // Hold the flag until a clear or an overflow.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (clr_i || wrap_i) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end
    end

    assign irq_o = flag_q;

endmodule

// File: rtl/win_watchdog.sv
// Module: win_watchdog (top)
// Windowed watchdog: period decode, tick counter, clear judge and flag.
// Assumes period_sel_i and win_mode_i change only right after a restart,
// and that every input is synchronous to clk_i.
module win_watchdog
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       clr_req_i,
    input  logic [2:0] period_sel_i,
    input  logic [1:0] win_mode_i,
    output logic       wdt_rst_o,
    output logic       irq_o
);

    localparam int CNT_W = BASE_LOG2 + LOG2_SPAN;

    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] open_cnt;
    logic [CNT_W-1:0] irq_cnt;
    logic             win_en;
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    wdt_period_decode #(
        .BASE_LOG2 (BASE_LOG2),
        .CNT_W     (CNT_W)
    ) u_decode (
        .period_sel_i (period_sel_i),
        .win_mode_i   (win_mode_i),
        .last_cnt_o   (last_cnt),
        .open_cnt_o   (open_cnt),
        .irq_cnt_o    (irq_cnt),
        .win_en_o     (win_en)
    );

    wdt_tick_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .restart_i  (clr_req_i),
        .last_cnt_i (last_cnt),
        .cnt_o      (cnt),
        .wrap_o     (wrap)
    );

    wdt_clear_judge #(
        .CNT_W (CNT_W)
    ) u_judge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (clr_req_i),
        .wrap_i     (wrap),
        .win_en_i   (win_en),
        .cnt_i      (cnt),
        .open_cnt_i (open_cnt),
        .wdt_rst_o  (wdt_rst_o)
    );

    wdt_irq_flag #(
        .CNT_W (CNT_W)
    ) u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .clr_i     (clr_req_i),
        .wrap_i    (wrap),
        .cnt_i     (cnt),
        .irq_cnt_i (irq_cnt),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/win_watchdog_chk.sv
// Module: win_watchdog_chk
// Property checker attached to win_watchdog by bind. It relates the
// inputs, the decoded window values and the counter state to the outputs.
module win_watchdog_chk #(
    parameter int CNT_W = 13
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             clr_req_i,
    input logic [2:0]       period_sel_i,
    input logic             wdt_rst_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] last_cnt,
    input logic [CNT_W-1:0] open_cnt,
    input logic             win_en
);

    // R1: reset clears the outputs and the count
    p_reset_state_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (cnt == '0) && !wdt_rst_o && !irq_o);

    // R2, R3: a completed period pulses reset and restarts the count
    p_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !clr_req_i && (cnt == last_cnt)) |=> wdt_rst_o && (cnt == '0));

    // R6: an early clear produces the reset pulse
    p_early_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_req_i && win_en && (cnt < open_cnt)) |=> wdt_rst_o);

    // R5: a clear inside the window produces no pulse and restarts the count
    p_valid_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_req_i && (!win_en || (cnt >= open_cnt))) |=> !wdt_rst_o && (cnt == '0));

    // R7: the short periods never open a window
    p_short_no_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_sel_i < 3'd4) |-> !win_en);

    // R9: any clear request drops the flag
    p_irq_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_req_i |=> !irq_o);

    // R10: idle cycles leave count and flag untouched and give no pulse
    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clr_req_i) |=> $stable(cnt) && $stable(irq_o) && !wdt_rst_o);

endmodule

bind win_watchdog win_watchdog_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .clr_req_i    (clr_req_i),
    .period_sel_i (period_sel_i),
    .wdt_rst_o    (wdt_rst_o),
    .irq_o        (irq_o),
    .cnt          (cnt),
    .last_cnt     (last_cnt),
    .open_cnt     (open_cnt),
    .win_en       (win_en)
);

// File: tb/win_watchdog_test.sv
// Bench for win_watchdog with a small period base (B = 2): periods of
// 4, 8, 16, 32, 64, 256, 1024 and 4096 ticks. Expected values are
// computed from the requirement arithmetic.
module win_watchdog_test;

    localparam int B = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       clr = 1'b0;
    logic [2:0] sel = 3'd0;
    logic [1:0] mode = 2'd0;
    logic       wrst;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    win_watchdog #(.BASE_LOG2(B)) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .clr_req_i    (clr),
        .period_sel_i (sel),
        .win_mode_i   (mode),
        .wdt_rst_o    (wrst),
        .irq_o        (irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    function automatic int plen(input int s);
        return (s < 4) ? (1 << (B + s)) : (1 << (B + 2 * s - 4));
    endfunction

    function automatic int open_at(input int s, input int m);
        if (s < 4 || m == 0 || m == 3) return 0;
        return (m == 1) ? plen(s) / 4 : plen(s) / 2;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s sel=%0d mode=%0d actual=%0b expected=%0b",
                     req, sel, mode, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic c);
        tick = t;
        clr  = c;
        @(posedge clk);
        #2;
        tick = 1'b0;
        clr  = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
    endtask

    task automatic do_reset(input int s, input int m);
        rst_n = 1'b0;
        sel   = 3'(s);
        mode  = 2'(m);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic clear_at(input int s, input int m, input int e);
        string req;
        int op;
        op = open_at(s, m);
        do_reset(s, m);
        ticks(e);
        cyc(1'b0, 1'b1);
        if (s < 4) req = "R7";
        else if (op == 0) req = "R4";
        else if (e < op) req = "R6";
        else req = "R5";
        check(req, wrst, (e < op) ? 1'b1 : 1'b0);
        check("R9", irq, 1'b0);
    endtask

    initial begin
        wait (cycles >= 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p;
        // R1: outputs low out of reset
        do_reset(0, 0);
        check("R1", wrst, 1'b0);
        check("R1", irq, 1'b0);

        // R2, R3, R9: free-running periods for every select and mode
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 4; m++) begin
                p = plen(s);
                do_reset(s, m);
                for (int pass = 0; pass < 2; pass++) begin
                    for (int i = 1; i <= p; i++) begin
                        cyc(1'b1, 1'b0);
                        check(pass == 0 ? "R2" : "R3", wrst, (i == p) ? 1'b1 : 1'b0);
                        check("R9", irq, (i >= (3 * p) / 4 && i < p) ? 1'b1 : 1'b0);
                    end
                    cyc(1'b0, 1'b0);
                    check("R3", wrst, 1'b0);
                end
            end
        end

        // R4, R5, R6, R7: clear position sweeps
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 4; m++) begin
                p = plen(s);
                if (s <= 4) begin
                    for (int e = 0; e < p; e++) clear_at(s, m, e);
                end else begin
                    clear_at(s, m, 0);
                    if (open_at(s, m) > 0) clear_at(s, m, open_at(s, m) - 1);
                    clear_at(s, m, open_at(s, m));
                    clear_at(s, m, p - 1);
                end
            end
        end

        // R8: tick and clear together, just below the window edge
        do_reset(4, 2);
        ticks(31);
        cyc(1'b1, 1'b1);
        check("R8", wrst, 1'b1);

        // R8, R5: tick and clear together at the edge; tick not counted
        do_reset(4, 2);
        ticks(32);
        cyc(1'b1, 1'b1);
        check("R8", wrst, 1'b0);
        ticks(63);
        check("R8", wrst, 1'b0);
        cyc(1'b1, 1'b0);
        check("R5", wrst, 1'b1);

        // R10, R9: idle cycles hold count and flag
        do_reset(4, 0);
        ticks(48);
        check("R9", irq, 1'b1);
        for (int i = 0; i < 40; i++) begin
            cyc(1'b0, 1'b0);
            check("R10", wrst, 1'b0);
        end
        check("R10", irq, 1'b1);
        ticks(15);
        check("R10", wrst, 1'b0);
        cyc(1'b1, 1'b0);
        check("R10", wrst, 1'b1);
        check("R9", irq, 1'b0);

        // R6, R9: invalid clear right after a pulse leaves flag low
        do_reset(5, 1);
        cyc(1'b0, 1'b1);
        check("R6", wrst, 1'b1);
        cyc(1'b0, 1'b1);
        check("R6", wrst, 1'b1);
        check("R9", irq, 1'b0);

        // R1: reset mid-period drops the flag and restarts the count
        do_reset(4, 0);
        ticks(50);
        do_reset(4, 0);
        check("R1", irq, 1'b0);
        ticks(63);
        check("R1", wrst, 1'b0);
        cyc(1'b1, 1'b0);
        check("R1", wrst, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule